// File: doc/BRIEF.md
# Compare-Match Timer with Waveform Output

This block is a 16-bit up-counter paired with a single compare unit that drives one waveform pin. A mode field picks how the counter runs. In wrap-around mode it counts freely up to full scale and rolls back to zero, setting a sticky overflow flag when it does. In the two clear-on-compare modes it counts up to a programmable ceiling and then restarts from zero. The ceiling comes from compare register A in one mode and from a separate top register in the other.

The compare unit watches for the count to equal compare register A. On a match it raises a sticky compare flag and applies the configured pin action, which is to leave the pin alone, toggle it, clear it or set it. A force strobe applies the same action at once, without a match and without touching the flag. The counter advances only on cycles where the tick enable is high, so an external prescaler can pace it. All configuration goes through one narrow write port. The two flags are cleared by writing ones to them through that port.

Top module: `cmp_timer`

## Requirements
- R1: After reset the count, both flags and the waveform pin are 0, and the mode, output mode, compare A and top registers are all 0.
- R2: The count changes only on a cycle where `tick` is high or the counter is written. In mode 0 each tick adds one, and 0xFFFF is followed by 0x0000.
- R3: The overflow flag is set on a tick where an increment takes the count from 0xFFFF to 0x0000, in any mode. A return to zero caused by reaching the top value does not set it. Once set, it stays set until it is cleared.
- R4: In mode 4, a tick on which the count equals compare A loads 0 into the count. Otherwise the count increments.
- R5: In mode 12, a tick on which the count equals the top register loads 0 into the count. Compare A does not limit the count in this mode.
- R6: Any mode value other than 4 and 12 behaves exactly as mode 0.
- R7: A tick on which the count equals compare A, in any mode, sets the compare flag and applies the output action on that same edge. The output modes are: 0 leaves the pin unchanged, 1 toggles it, 2 clears it and 3 sets it.
- R8: Writing the output mode does not change the pin. The new value acts only at the next match or force.
- R9: A write with select 5 (force) applies the current output action on that edge and does not set the compare flag. When a force and a match fall on the same edge, the action is applied once.
- R10: A write with select 6 clears the overflow flag if data bit 0 is 1 and clears the compare flag if data bit 1 is 1. A flag that is set and cleared on the same edge ends up set.
- R11: A counter write (select 0) loads `wr_data` on any cycle and in any mode, taking priority over the tick's increment. On that cycle there is no match and no overflow.
- R12: Write selects: 0 counter, 1 compare A, 2 top register, 3 mode (data bits 3:0), 4 output mode (data bits 1:0), 5 force, 6 flag clear. Select 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable. Matches and flag sets occur only on ticks |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target select (see R12) |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |
| wave | output | 1 | Waveform pin |

## Verification
Every result is registered, so the count, the flags and the pin all reflect a stimulus on the first rising edge after it is presented. This holds for matches, forces and counter writes alike, and for the top-value clear in both clear-on-compare modes. The bench drives inputs on the falling edge and advances its own model just after the following rising edge using those inputs. It then compares all four outputs at once, every cycle. Because of this, a result that lands one edge early or late shows up as a miscompare on that exact cycle.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int W  = 16,
  parameter int MW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic         ovf_flag,
  output logic         cmp_flag,
  output logic         wave
);
  localparam logic [W-1:0]  MAXV    = {W{1'b1}};
  localparam logic [MW-1:0] MODE_CA = MW'(4);
  localparam logic [MW-1:0] MODE_CT = MW'(12);

  logic [W-1:0]  cmpa, topr;
  logic [MW-1:0] mode;
  logic [1:0]    omode;

  wire wr_cnt  = wr_en && (wr_sel == 3'd0);
  wire wr_cmpa = wr_en && (wr_sel == 3'd1);
  wire wr_top  = wr_en && (wr_sel == 3'd2);
  wire wr_mode = wr_en && (wr_sel == 3'd3);
  wire wr_om   = wr_en && (wr_sel == 3'd4);
  wire force_s = wr_en && (wr_sel == 3'd5);
  wire clr_s   = wr_en && (wr_sel == 3'd6);

  wire           ctc     = (mode == MODE_CA) || (mode == MODE_CT);
  wire [W-1:0]   top_val = (mode == MODE_CT) ? topr : cmpa;
  wire           adv     = tick && !wr_cnt;
  wire           at_top  = ctc && (count == top_val);
  wire           match   = adv && (count == cmpa);
  wire           roll    = adv && !at_top && (count == MAXV);
  wire           act     = match || force_s;

  logic wave_nx;
  always_comb begin
    case (omode)
      2'd1:    wave_nx = ~wave;
      2'd2:    wave_nx = 1'b0;
      2'd3:    wave_nx = 1'b1;
      default: wave_nx = wave;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      cmpa     <= '0;
      topr     <= '0;
      mode     <= '0;
      omode    <= '0;
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
      wave     <= 1'b0;
    end else begin
      if (wr_cnt)       count <= wr_data;
      else if (tick)    count <= at_top ? '0 : count + 1'b1;
      if (wr_cmpa)      cmpa  <= wr_data;
      if (wr_top)       topr  <= wr_data;
      if (wr_mode)      mode  <= wr_data[MW-1:0];
      if (wr_om)        omode <= wr_data[1:0];
      if (act)          wave  <= wave_nx;
      ovf_flag <= roll  || (ovf_flag && !(clr_s && wr_data[0]));
      cmp_flag <= match || (cmp_flag && !(clr_s && wr_data[1]));
    end
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(count));

  // R3
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(tick) && $past(count) == MAXV && count == '0));

  // R4
  top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ctc && count == top_val) |=> (count == '0));

  // R8
  wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !force_s) |=> $stable(wave));

  // R9
  force_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_s && !tick && !cmp_flag) |=> !cmp_flag);

  // R10
  cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_s && wr_data[1] && !match) |=> !cmp_flag);
endmodule

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        ovf_flag, cmp_flag, wave;

  int vectors = 0, errors = 0;
  string req = "R1";
  bit live = 1'b0;

  int m_cnt, m_cmpa, m_top, m_mode, m_om;
  bit m_ovf, m_cmp, m_wave;

  always #10 clk = ~clk;

  cmp_timer u_dut (.clk, .rst_n, .tick, .wr_en, .wr_sel, .wr_data,
                   .count, .ovf_flag, .cmp_flag, .wave);

  task automatic compare();
    vectors++;
    if (count !== 16'(m_cnt) || ovf_flag !== m_ovf || cmp_flag !== m_cmp || wave !== m_wave) begin
      errors++;
      $display("FAIL %s: cnt/ovf/cmp/wave got %h/%b/%b/%b expected %h/%b/%b/%b",
               req, count, ovf_flag, cmp_flag, wave, 16'(m_cnt), m_ovf, m_cmp, m_wave);
    end
  endtask

  task automatic model_step();
    bit wc, ctc, attop, mt, rl, act, clr_o, clr_c;
    int topv;
    wc    = wr_en && wr_sel == 0;
    ctc   = (m_mode == 4) || (m_mode == 12);
    topv  = (m_mode == 12) ? m_top : m_cmpa;
    attop = ctc && m_cnt == topv;
    mt    = tick && !wc && m_cnt == m_cmpa;
    rl    = tick && !wc && !attop && m_cnt == 65535;
    act   = mt || (wr_en && wr_sel == 5);
    clr_o = wr_en && wr_sel == 6 && wr_data[0];
    clr_c = wr_en && wr_sel == 6 && wr_data[1];
    if (act) begin
      if (m_om == 1) m_wave = !m_wave;
      else if (m_om == 2) m_wave = 1'b0;
      else if (m_om == 3) m_wave = 1'b1;
    end
    m_ovf = rl || (m_ovf && !clr_o);
    m_cmp = mt || (m_cmp && !clr_c);
    if (wc) m_cnt = wr_data;
    else if (tick) m_cnt = attop ? 0 : (m_cnt + 1) % 65536;
    if (wr_en && wr_sel == 1) m_cmpa = wr_data;
    if (wr_en && wr_sel == 2) m_top  = wr_data;
    if (wr_en && wr_sel == 3) m_mode = wr_data[3:0];
    if (wr_en && wr_sel == 4) m_om   = wr_data[1:0];
  endtask

  always @(posedge clk) begin
    if (live) begin
      #1;
      model_step();
      compare();
    end
  end

  task automatic cyc(input bit t, input bit we, input int sel, input int data);
    @(negedge clk);
    tick = t; wr_en = we; wr_sel = 3'(sel); wr_data = 16'(data);
  endtask

  task automatic wr(input int sel, input int data, input bit t = 1'b0);
    cyc(t, 1'b1, sel, data);
  endtask

  task automatic run(input int n, input bit t = 1'b1);
    for (int i = 0; i < n; i++) cyc(t, 1'b0, 0, 0);
  endtask

  initial begin
    m_cnt = 0; m_cmpa = 0; m_top = 0; m_mode = 0; m_om = 0;
    m_ovf = 0; m_cmp = 0; m_wave = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req = "R1"; compare();
    live = 1'b1;
    wr(1, 16'h8000);
    req = "R2"; run(5, 1'b0); run(10);
    for (int i = 0; i < 4; i++) begin cyc(1'b0, 1'b0, 0, 0); cyc(1'b1, 1'b0, 0, 0); end
    req = "R3"; wr(0, 16'hFFFC); run(8);
    req = "R10"; wr(6, 1); wr(0, 16'hFFFE); cyc(1'b1, 1'b0, 0, 0); cyc(1'b1, 1'b1, 6, 1); run(2);
    req = "R11"; wr(0, 16'hFFFF, 1'b1); wr(0, 16'h1234, 1'b1); run(3); wr(0, 16'h8000, 1'b1);
    req = "R4"; wr(1, 5); wr(3, 4); wr(0, 0); run(20);
    wr(0, 9); run(3);
    req = "R5"; wr(2, 3); wr(3, 12); wr(0, 0); run(15);
    req = "R6"; wr(3, 7); wr(0, 16'hFFFD); run(6); wr(3, 15); run(8);
    req = "R7"; wr(3, 4); wr(1, 3); wr(4, 1); wr(0, 0); run(12);
    wr(4, 3); run(5); wr(4, 2); run(5);
    req = "R8"; wr(4, 3); run(2, 1'b0); wr(4, 1); run(2, 1'b0); run(6);
    req = "R9"; wr(4, 1); wr(5, 0); wr(5, 0); wr(0, 3); wr(5, 0, 1'b1); wr(4, 3); wr(5, 0); wr(4, 2); wr(5, 0);
    wr(4, 0); wr(5, 0); run(4);
    req = "R12"; wr(7, 16'hFFFF, 1'b1); run(3);
    req = "R10"; wr(6, 2); wr(6, 3); run(2);
    req = "RAND";
    for (int i = 0; i < 4000; i++) begin
      int s, d;
      s = $urandom_range(0, 7);
      d = $urandom_range(0, 12);
      if (s == 3) d = ($urandom_range(0, 2) == 0) ? 4 : (($urandom_range(0, 1) == 0) ? 12 : $urandom_range(0, 15));
      if (s == 0 && $urandom_range(0, 5) == 0) d = 16'hFFF0 + $urandom_range(0, 15);
      cyc(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) == 0), s, d);
    end
    run(2);
    live = 1'b0;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL %s: watchdog expired, got running expected done", req);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule